// File: doc/BRIEF.md
# NAND Write-Cycle Strobe Sequencer

This block sits on the host side of an 8-bit NAND flash bus. It drives the bus pins for write-type cycles: command, address and data bytes. Bytes arrive on a valid/ready stream. Each byte carries a two-bit kind tag and a flag that marks the final byte of an address phase. For every accepted byte the block produces one timed cycle. Chip enable goes low and the latch-enable line for that kind is raised. The byte is driven onto the data bus with its output enable. The write strobe is then pulsed low and released, and the rising edge of that strobe is the point where the flash device latches the byte.

The block runs from the system clock. Every minimum interval is expressed in nanoseconds for two device speed grades and rounded up to whole clock cycles from a clock-period parameter. The result is four phase lengths: setup, strobe-low, hold, and an extra idle gap inserted after a final address byte. That gap guarantees the required spacing between the last address strobe and the first data strobe. Each length can be overridden by a parameter. A one-cycle done pulse marks the last hold cycle of each byte.

Top module: `nand_wseq`

## Requirements
- R1: After reset the bus is idle: CE# high, WE# high, CLE and ALE low, data bus zero with drive enable low, done low, and in_ready high.
- R2: Within each byte cycle, WE# stays low for exactly WE_LO_CYC clock cycles, which is ceil(tWP / clock period) for the selected grade (25 ns slow, 15 ns fast).
- R3: CE# falls, and CLE, ALE and the data byte become valid, SETUP_CYC cycles before WE# falls. SETUP_CYC is the larger of 1 and the rounded largest setup minimum (CE#, CLE, ALE, data) minus WE_LO_CYC.
- R4: After WE# rises, CE#, CLE, ALE and the data stay unchanged for HOLD_CYC cycles. HOLD_CYC is the larger of the rounded largest hold/WE#-high minimum and the rounded write period minus SETUP_CYC minus WE_LO_CYC. Consecutive WE# rising edges are therefore at least the write period apart.
- R5: in_kind encodes 2'b00 = command, 2'b01 = address, any other value = data. CLE is high for the whole cycle of a command byte only, ALE for an address byte only, and the two are never high together.
- R6: While CE# is low the data bus carries the accepted byte and nand_dq_oe is high. While CE# is high the bus drives zero with nand_dq_oe low.
- R7: in_ready is high only when no byte cycle or gap is in progress. A byte is taken on a clock edge where in_valid and in_ready are both high, so a valid held high during a cycle starts no second cycle.
- R8: After an address byte with in_last set, CE# returns high and in_ready stays low for GAP_CYC extra cycles. GAP_CYC is the larger of 0 and ceil(100 ns / clock period) − HOLD_CYC − SETUP_CYC − WE_LO_CYC − 1. A following data byte's WE# rising edge is therefore at least 100 ns after the address byte's.
- R9: cyc_done is high for exactly one clock per byte, in the last hold cycle while CE# is still low, and CE# is high in the next cycle.
- R10: in_last has no effect on command or data bytes: no gap follows them and in_ready returns high as soon as CE# rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered on the input stream |
| in_ready | output | 1 | Sequencer can take a byte this cycle |
| in_kind | input | 2 | 00 command, 01 address, other data |
| in_last | input | 1 | Marks the final address byte |
| in_byte | input | 8 | Byte value to place on the bus |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, device latches on its rising edge |
| nand_dq | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus drive enable |
| cyc_done | output | 1 | One-cycle pulse at the end of each byte cycle |

## Verification
The checker measures phase lengths from the pins: WE# low time, CE# low time before a rise, hold after a rise, and rise-to-rise spacing. It compares them with the nanosecond minimums rounded up to cycles. These measurements assume an asynchronous reset that is held until the first rising clock edge, and inputs that change only away from the clock edge. The gap check assumes the final-address flag is held by the design for the whole cycle, so it needs no stable input. The bench drives every input at the falling clock edge. It raises in_valid only when in_ready is seen high, except in the one scenario that holds in_valid high on purpose through a whole cycle.

// File: rtl/nand_wseq_pkg.sv
package nand_wseq_pkg;

  typedef enum logic [1:0] {
    KIND_CMD  = 2'b00,
    KIND_ADDR = 2'b01,
    KIND_DATA = 2'b10
  } byte_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_WELO  = 3'd2,
    PH_HOLD  = 3'd3,
    PH_GAP   = 3'd4
  } phase_e;

  typedef enum logic [3:0] {
    TM_PERIOD, TM_WE_LO, TM_WE_HI,
    TM_CLE_SU, TM_CLE_HD, TM_CE_SU, TM_CE_HD,
    TM_ALE_SU, TM_ALE_HD, TM_DQ_SU, TM_DQ_HD, TM_ADDR_DATA
  } tmin_e;

  // minimum interval in ns; fast selects the quicker grade
  function automatic int min_ns(bit fast, tmin_e t);
    case (t)
      TM_PERIOD:    return fast ? 30 : 45;
      TM_WE_LO:     return fast ? 15 : 25;
      TM_WE_HI:     return fast ? 10 : 15;
      TM_CLE_SU:    return fast ? 10 : 25;
      TM_CLE_HD:    return fast ? 5  : 10;
      TM_CE_SU:     return fast ? 15 : 35;
      TM_CE_HD:     return fast ? 5  : 10;
      TM_ALE_SU:    return fast ? 10 : 25;
      TM_ALE_HD:    return fast ? 5  : 10;
      TM_DQ_SU:     return fast ? 10 : 20;
      TM_DQ_HD:     return fast ? 5  : 10;
      default:      return 100;
    endcase
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // round a ns interval up to whole clock cycles
  function automatic int ns2cyc(int ns, int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int tcyc(bit fast, tmin_e t, int clk_ps);
    return ns2cyc(min_ns(fast, t), clk_ps);
  endfunction

  // cycles a strobe must be valid before the WE# rising edge
  function automatic int setup_need(bit fast, int clk_ps);
    return imax(imax(tcyc(fast, TM_CLE_SU, clk_ps), tcyc(fast, TM_CE_SU, clk_ps)),
                imax(tcyc(fast, TM_ALE_SU, clk_ps), tcyc(fast, TM_DQ_SU, clk_ps)));
  endfunction

  // cycles after the WE# rising edge before anything may move
  function automatic int hold_need(bit fast, int clk_ps);
    return imax(tcyc(fast, TM_WE_HI, clk_ps),
                imax(imax(tcyc(fast, TM_CLE_HD, clk_ps), tcyc(fast, TM_CE_HD, clk_ps)),
                     imax(tcyc(fast, TM_ALE_HD, clk_ps), tcyc(fast, TM_DQ_HD, clk_ps))));
  endfunction

  function automatic int welo_cyc(bit fast, int clk_ps);
    return imax(1, tcyc(fast, TM_WE_LO, clk_ps));
  endfunction

  function automatic int setup_cyc(bit fast, int clk_ps);
    return imax(1, setup_need(fast, clk_ps) - welo_cyc(fast, clk_ps));
  endfunction

  function automatic int hold_cyc(bit fast, int clk_ps);
    return imax(imax(1, hold_need(fast, clk_ps)),
                tcyc(fast, TM_PERIOD, clk_ps) - setup_cyc(fast, clk_ps) - welo_cyc(fast, clk_ps));
  endfunction

  // extra idle cycles after a final address byte; one idle cycle always follows
  function automatic int gap_cyc(bit fast, int clk_ps);
    return imax(0, tcyc(fast, TM_ADDR_DATA, clk_ps) - hold_cyc(fast, clk_ps)
                   - setup_cyc(fast, clk_ps) - welo_cyc(fast, clk_ps) - 1);
  endfunction

endpackage

// File: rtl/nand_wseq_cnt.sv
module nand_wseq_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (load)     cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/nand_wseq_ctrl.sv
module nand_wseq_ctrl
  import nand_wseq_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WE_LO_CYC = 1,
  parameter int HOLD_CYC  = 1,
  parameter int GAP_CYC   = 0,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_kind,
  input  logic             in_last,
  input  logic             cnt_zero,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output phase_e           phase,
  output logic             in_ready,
  output logic             evt_accept,
  output logic             evt_we_rise,
  output logic             evt_cyc_end,
  output logic             last_addr_q
);

  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WELO  = CNT_W'(WE_LO_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_GAP   = CNT_W'((GAP_CYC > 0) ? GAP_CYC - 1 : 0);
  localparam bit               HAS_GAP  = (GAP_CYC > 0);

  phase_e phase_q, phase_d;

  assign in_ready    = (phase_q == PH_IDLE);
  assign evt_accept  = in_ready && in_valid;
  assign evt_we_rise = (phase_q == PH_WELO) && cnt_zero;
  assign evt_cyc_end = (phase_q == PH_HOLD) && cnt_zero;
  assign phase       = phase_q;

  always_comb begin
    phase_d  = phase_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    case (phase_q)
      PH_IDLE: if (evt_accept) begin
        phase_d = PH_SETUP; cnt_load = 1'b1; cnt_val = LD_SETUP;
      end
      PH_SETUP: if (cnt_zero) begin
        phase_d = PH_WELO; cnt_load = 1'b1; cnt_val = LD_WELO;
      end
      PH_WELO: if (evt_we_rise) begin
        phase_d = PH_HOLD; cnt_load = 1'b1; cnt_val = LD_HOLD;
      end
      PH_HOLD: if (evt_cyc_end) begin
        if (HAS_GAP && last_addr_q) begin
          phase_d = PH_GAP; cnt_load = 1'b1; cnt_val = LD_GAP;
        end else begin
          phase_d = PH_IDLE;
        end
      end
      PH_GAP: if (cnt_zero) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      last_addr_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (evt_accept)
        last_addr_q <= (byte_kind_e'(in_kind) == KIND_ADDR) && in_last;
    end
  end

endmodule

// File: rtl/nand_wseq_bus.sv
module nand_wseq_bus
  import nand_wseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic [1:0] in_kind,
  input  logic [7:0] in_byte,
  input  phase_e     phase,
  output logic       nand_ce_n,
  output logic       nand_cle,
  output logic       nand_ale,
  output logic       nand_we_n,
  output logic [7:0] nand_dq,
  output logic       nand_dq_oe
);

  logic [7:0] byte_q;
  logic       is_cmd_q;
  logic       is_addr_q;
  logic       on_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q    <= '0;
      is_cmd_q  <= 1'b0;
      is_addr_q <= 1'b0;
    end else if (capture) begin
      byte_q    <= in_byte;
      is_cmd_q  <= (byte_kind_e'(in_kind) == KIND_CMD);
      is_addr_q <= (byte_kind_e'(in_kind) == KIND_ADDR);
    end
  end

  always_comb begin
    case (phase)
      PH_SETUP, PH_WELO, PH_HOLD: on_bus = 1'b1;
      default:                    on_bus = 1'b0;
    endcase
  end

  assign nand_ce_n  = !on_bus;
  assign nand_cle   = on_bus && is_cmd_q;
  assign nand_ale   = on_bus && is_addr_q;
  assign nand_we_n  = (phase != PH_WELO);
  assign nand_dq    = on_bus ? byte_q : 8'h00;
  assign nand_dq_oe = on_bus;

endmodule

// File: rtl/nand_wseq.sv
module nand_wseq
  import nand_wseq_pkg::*;
#(
  parameter int CLK_PS     = 10000,
  parameter bit FAST_GRADE = 1'b0,
  parameter int SETUP_CYC  = setup_cyc(FAST_GRADE, CLK_PS),
  parameter int WE_LO_CYC  = welo_cyc(FAST_GRADE, CLK_PS),
  parameter int HOLD_CYC   = hold_cyc(FAST_GRADE, CLK_PS),
  parameter int GAP_CYC    = gap_cyc(FAST_GRADE, CLK_PS)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [1:0] in_kind,
  input  logic       in_last,
  input  logic [7:0] in_byte,
  output logic       nand_ce_n,
  output logic       nand_cle,
  output logic       nand_ale,
  output logic       nand_we_n,
  output logic [7:0] nand_dq,
  output logic       nand_dq_oe,
  output logic       cyc_done
);

  localparam int LONGEST = imax(imax(SETUP_CYC, WE_LO_CYC), imax(HOLD_CYC, GAP_CYC));
  localparam int CNT_W   = imax(1, $clog2(LONGEST + 1));

  phase_e           phase;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;
  // named events, also observed by the bound checker
  logic             evt_accept;
  logic             evt_we_rise;
  logic             evt_cyc_end;
  logic             cur_last_addr;

  nand_wseq_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  nand_wseq_ctrl #(
    .SETUP_CYC (SETUP_CYC),
    .WE_LO_CYC (WE_LO_CYC),
    .HOLD_CYC  (HOLD_CYC),
    .GAP_CYC   (GAP_CYC),
    .CNT_W     (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_kind     (in_kind),
    .in_last     (in_last),
    .cnt_zero    (cnt_zero),
    .cnt_load    (cnt_load),
    .cnt_val     (cnt_val),
    .phase       (phase),
    .in_ready    (in_ready),
    .evt_accept  (evt_accept),
    .evt_we_rise (evt_we_rise),
    .evt_cyc_end (evt_cyc_end),
    .last_addr_q (cur_last_addr)
  );

  nand_wseq_bus u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (evt_accept),
    .in_kind    (in_kind),
    .in_byte    (in_byte),
    .phase      (phase),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_dq    (nand_dq),
    .nand_dq_oe (nand_dq_oe)
  );

  assign cyc_done = evt_cyc_end;

endmodule

// File: rtl/nand_wseq_chk.sv
module nand_wseq_chk
  import nand_wseq_pkg::*;
#(
  parameter int CLK_PS     = 10000,
  parameter bit FAST_GRADE = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic [7:0] nand_dq,
  input logic       cyc_done,
  input logic       cur_last_addr
);

  localparam int MIN_WP  = tcyc(FAST_GRADE, TM_WE_LO, CLK_PS);
  localparam int MIN_SU  = setup_need(FAST_GRADE, CLK_PS);
  localparam int MIN_HD  = hold_need(FAST_GRADE, CLK_PS);
  localparam int MIN_WC  = tcyc(FAST_GRADE, TM_PERIOD, CLK_PS);
  localparam int MIN_ADL = tcyc(FAST_GRADE, TM_ADDR_DATA, CLK_PS);

  logic        we_q, ce_q, adl_armed;
  logic [15:0] lo_n, su_n, hd_n, r2r_n;
  logic        we_rise_pin, ce_rise_pin;

  assign we_rise_pin = nand_we_n && !we_q;
  assign ce_rise_pin = nand_ce_n && !ce_q;

  function automatic logic [15:0] sat_inc(logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1; ce_q <= 1'b1; adl_armed <= 1'b0;
      lo_n <= '0; su_n <= '0; hd_n <= '0; r2r_n <= 16'hFFFF;
    end else begin
      we_q  <= nand_we_n;
      ce_q  <= nand_ce_n;
      lo_n  <= nand_we_n ? 16'd0 : sat_inc(lo_n);
      su_n  <= nand_ce_n ? 16'd0 : sat_inc(su_n);
      hd_n  <= we_rise_pin ? 16'd1 : (nand_ce_n ? hd_n : sat_inc(hd_n));
      r2r_n <= we_rise_pin ? 16'd1 : sat_inc(r2r_n);
      if (we_rise_pin) adl_armed <= cur_last_addr;
    end
  end

  // R2
  we_low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_rise_pin |-> (lo_n >= 16'(MIN_WP)));

  // R3
  strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_rise_pin |-> (su_n >= 16'(MIN_SU)));

  // R4
  strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise_pin |-> (hd_n >= 16'(MIN_HD)));

  // R4
  write_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_rise_pin |-> (r2r_n >= 16'(MIN_WC)));

  // R8
  addr_data_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_rise_pin && adl_armed && !nand_cle && !nand_ale) |-> (r2r_n >= 16'(MIN_ADL)));

  // R5
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  // R6
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_ce_n && !ce_q) |-> ($stable(nand_dq) && $stable(nand_cle) && $stable(nand_ale)));

  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_ce_n |-> !in_ready);

  // R9
  done_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |-> (!nand_ce_n && nand_we_n));

  // R9
  done_then_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> nand_ce_n);

endmodule

bind nand_wseq nand_wseq_chk #(.CLK_PS(CLK_PS), .FAST_GRADE(FAST_GRADE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .nand_ce_n     (nand_ce_n),
  .nand_cle      (nand_cle),
  .nand_ale      (nand_ale),
  .nand_we_n     (nand_we_n),
  .nand_dq       (nand_dq),
  .cyc_done      (cyc_done),
  .cur_last_addr (cur_last_addr)
);

// File: tb/nand_wseq_tb.sv
module nand_wseq_tb;

  localparam int CLK_PS = 10000;

  // slow-grade minimums restated here in ns
  function automatic int cdiv(int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction
  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int EP  = cdiv(25);
  localparam int ES  = mx(1, cdiv(35) - EP);
  localparam int EH  = mx(cdiv(15), cdiv(45) - ES - EP);
  localparam int EG  = mx(0, cdiv(100) - EH - ES - EP - 1);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [1:0] in_kind = 2'b00;
  logic       in_last = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_dq_oe, cyc_done;
  logic [7:0] nand_dq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nand_wseq u_dut (
    .clk (clk), .rst_n (rst_n),
    .in_valid (in_valid), .in_ready (in_ready),
    .in_kind (in_kind), .in_last (in_last), .in_byte (in_byte),
    .nand_ce_n (nand_ce_n), .nand_cle (nand_cle), .nand_ale (nand_ale),
    .nand_we_n (nand_we_n), .nand_dq (nand_dq), .nand_dq_oe (nand_dq_oe),
    .cyc_done (cyc_done)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // measurements of the most recent byte cycle
  int s_ce_lo, s_pre, s_we_lo, s_pulses, s_done, s_done_at, s_rise, s_prev_rise;
  logic [7:0] s_dq;
  bit s_cle_ok, s_ale_ok, s_oe_ok, s_rdy_ok, s_idle_ok;

  // caller stands at a falling edge
  task automatic send(logic [1:0] kind, bit last, logic [7:0] b, bit hold_valid);
    bit seen, prev_lo;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_kind = kind; in_last = last; in_byte = b;
    s_ce_lo = 0; s_pre = 0; s_we_lo = 0; s_pulses = 0; s_done = 0; s_done_at = 0;
    s_cle_ok = 1; s_ale_ok = 1; s_oe_ok = 1; s_rdy_ok = 1;
    s_prev_rise = s_rise;
    seen = 0; prev_lo = 0;
    @(posedge clk);
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (!hold_valid) in_valid = 1'b0;
      if (nand_ce_n && seen) break;
      if (!nand_ce_n) begin
        seen = 1;
        s_ce_lo++;
        if (nand_we_n && s_we_lo == 0) s_pre++;
        if (!nand_we_n) begin
          s_we_lo++; s_dq = nand_dq;
          if (!prev_lo) s_pulses++;
        end
        if (nand_we_n && prev_lo) s_rise = cyc;
        if (nand_cle != (kind == 2'b00)) s_cle_ok = 0;
        if (nand_ale != (kind == 2'b01)) s_ale_ok = 0;
        if (!nand_dq_oe) s_oe_ok = 0;
        if (in_ready) s_rdy_ok = 0;
        if (cyc_done) begin s_done++; s_done_at = s_ce_lo; end
      end
      prev_lo = !nand_we_n;
    end
    in_valid = 1'b0;
    s_idle_ok = nand_ce_n && nand_we_n && !nand_dq_oe && (nand_dq == 8'h00)
                && !nand_cle && !nand_ale && !cyc_done;
  endtask

  task automatic count_gap(output int n);
    n = 0;
    while (!in_ready && n < 100) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(nand_ce_n && nand_we_n, "R1 strobes idle", {nand_ce_n, nand_we_n}, 3);
    chk(!nand_cle && !nand_ale, "R1 latch enables low", {nand_cle, nand_ale}, 0);
    chk(!nand_dq_oe && nand_dq == 8'h00, "R1 bus released", nand_dq, 0);
    chk(in_ready && !cyc_done, "R1 ready/done", {in_ready, cyc_done}, 2);
  endtask

  task automatic t_command();
    int g;
    send(2'b00, 1'b0, 8'h3C, 1'b0);
    chk(s_we_lo == EP, "R2 WE# low cycles", s_we_lo, EP);
    chk(s_pre == ES, "R3 setup before WE# fall", s_pre, ES);
    chk(s_ce_lo - s_pre - s_we_lo == EH, "R4 hold after WE# rise", s_ce_lo - s_pre - s_we_lo, EH);
    chk(s_cle_ok && s_ale_ok, "R5 CLE for command", {s_cle_ok, s_ale_ok}, 3);
    chk(s_dq == 8'h3C && s_oe_ok, "R6 command byte on bus", s_dq, 8'h3C);
    chk(s_idle_ok, "R6 bus released after cycle", s_idle_ok, 1);
    chk(s_done == 1 && s_done_at == s_ce_lo, "R9 done in last hold cycle", s_done_at, s_ce_lo);
    chk(s_rdy_ok, "R7 ready low while busy", s_rdy_ok, 1);
    count_gap(g);
    chk(g == 0, "R10 no gap after command", g, 0);
  endtask

  task automatic t_addr_data();
    int g, d;
    send(2'b01, 1'b0, 8'h12, 1'b0);
    chk(s_ale_ok && s_cle_ok, "R5 ALE for address", {s_ale_ok, s_cle_ok}, 3);
    chk(s_dq == 8'h12, "R6 address byte on bus", s_dq, 8'h12);
    count_gap(g);
    chk(g == 0, "R8 no gap after non-final address", g, 0);
    send(2'b01, 1'b1, 8'h34, 1'b0);
    count_gap(g);
    chk(g == EG, "R8 gap cycles after final address", g, EG);
    send(2'b10, 1'b0, 8'hA5, 1'b0);
    d = s_rise - s_prev_rise;
    chk(d == EH + EG + 1 + ES + EP, "R8 address-to-data rise spacing", d, EH + EG + 1 + ES + EP);
    chk(d >= cdiv(100), "R8 spacing meets 100 ns", d, cdiv(100));
    chk(s_cle_ok && s_ale_ok && s_dq == 8'hA5, "R5 data byte strobes", s_dq, 8'hA5);
    chk(s_we_lo == EP && s_pre == ES, "R2 data WE# low", s_we_lo, EP);
  endtask

  task automatic t_back_to_back();
    int d;
    send(2'b10, 1'b0, 8'h5A, 1'b0);
    send(2'b11, 1'b0, 8'hC3, 1'b0);
    d = s_rise - s_prev_rise;
    chk(d == EH + 1 + ES + EP, "R4 back-to-back rise spacing", d, EH + 1 + ES + EP);
    chk(d >= cdiv(45), "R4 write period met", d, cdiv(45));
    chk(s_dq == 8'hC3 && s_cle_ok && s_ale_ok, "R5 kind 11 treated as data", s_dq, 8'hC3);
  endtask

  task automatic t_last_ignored();
    int g;
    send(2'b00, 1'b1, 8'h80, 1'b0);
    count_gap(g);
    chk(g == 0, "R10 last flag ignored on command", g, 0);
    send(2'b10, 1'b1, 8'h01, 1'b0);
    count_gap(g);
    chk(g == 0, "R10 last flag ignored on data", g, 0);
  endtask

  task automatic t_hold_valid();
    bit quiet;
    send(2'b10, 1'b0, 8'h77, 1'b1);
    chk(s_pulses == 1, "R7 one strobe while valid held", s_pulses, 1);
    chk(s_rdy_ok, "R7 ready low through cycle", s_rdy_ok, 1);
    quiet = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (!nand_ce_n || !nand_we_n) quiet = 0;
    end
    chk(quiet, "R7 no second cycle after valid drops", quiet, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_command();
    t_addr_data();
    t_back_to_back();
    t_last_ignored();
    t_hold_valid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule